// File: doc/BRIEF.md
# Auto-Incrementing Board Identification Reader

This block is a read-only identity port on a small register bus that can move either one byte or a 16-bit word per access. Software learns what board it is talking to by reading one data location over and over. Each read returns the next entry of a fixed identity table, because an internal index advances as a side effect of the read. The table is built from parameters and is never stored. In order, it holds a two-byte device code, a two-byte vendor code, a two-byte logic revision (least significant digit first), four reserved filler bytes, and an eight-character board name padded with NUL. Every index beyond the name reads as FFh.

Two neighbouring offsets both feed the data stream. A byte read of the offset two above the first data offset rewinds the index to zero, so software can start a fresh scan without a reset. A word read returns the entry at the index in the low byte and the next entry in the high byte, and then moves the index on by two. The index is 8 bits wide, so it wraps from 255 back to 0.

Top module: `board_id_reader`

## Requirements
- R1: When `rst` is high at a clock edge, the index becomes 0 and `rvalid` and `rdata` become 0 at that edge.
- R2: A byte read (`wide`=0) at offset 0 or offset 1 returns table[index] on `rdata[7:0]` with `rdata[15:8]`=0, one cycle later with `rvalid`=1. The index then advances by 1.
- R3: A word read (`wide`=1) at offset 0 or offset 1 returns table[index] on `rdata[7:0]` and table[index+1] on `rdata[15:8]`. The index then advances by 2.
- R4: A byte read at offset 2 sets the index to 0 and returns `rdata`=0 with `rvalid`=1. A word read at offset 2 returns 0 and leaves the index unchanged.
- R5: Table entries 0..9 are 54h, 68h, 35h, 14h, then the revision low digit (default 02h), the revision high digit (default 01h), and four reserved bytes (default 00h).
- R6: Table entries 10..17 are the board name, first character at entry 10 (default "ISODIO" followed by two NUL bytes).
- R7: Table entries 18..255 read as FFh.
- R8: The index wraps modulo 256. A word read at index 255 returns FFh in the low byte and 54h in the high byte, and leaves the index at 1.
- R9: Writes to any offset, and reads of offset 3, leave the index unchanged. A read of offset 3 returns 0 with `rvalid`=1. `rvalid` is high exactly in the cycle after a read and low otherwise, and `rdata` is 0 whenever no data byte is being returned.
- R10: A cycle with both `rd_en` and `wr_en` high is not an access. The index does not move, and the next cycle shows `rvalid`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_en | input | 1 | Write strobe for this cycle (always ignored) |
| addr | input | 2 | Offset within the port (0, 1 data; 2 rewind) |
| wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | High in the cycle after an accepted read |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a read and a write: the bench raises `rd_en` and `wr_en` together at the rewind offset while the index is non-zero, then reads a byte to confirm that nothing moved. The second pair is the two-byte fetch and the index wrap: a word read issued at index 255 must pull the high byte from entry 0 and leave the index at 1. Random mixes of byte, word, rewind, stray and colliding accesses are judged against a bench model of the table and the index.

// File: rtl/bid_pkg.sv
package bid_pkg;

    typedef enum logic [1:0] {
        BID_IDLE   = 2'd0,
        BID_BYTE   = 2'd1,
        BID_WORD   = 2'd2,
        BID_REWIND = 2'd3
    } bid_op_e;

    localparam int unsigned BID_NAME_BYTES = 8;
    localparam int unsigned BID_RSVD_BASE  = 6;
    localparam int unsigned BID_NAME_BASE  = 10;
    localparam int unsigned BID_FILL_BASE  = BID_NAME_BASE + BID_NAME_BYTES;

    typedef struct packed {
        logic [15:0]                  dev;
        logic [15:0]                  ven;
        logic [15:0]                  rev;
        logic [7:0]                   rsvd;
        logic [8*BID_NAME_BYTES-1:0]  name;
    } bid_table_t;

    // Entry idx of the identity sequence; name characters are taken MSB first.
    function automatic logic [7:0] bid_lookup(input bid_table_t t, input int unsigned idx);
        logic [7:0] b;
        if (idx == 0)                  b = t.dev[7:0];
        else if (idx == 1)             b = t.dev[15:8];
        else if (idx == 2)             b = t.ven[7:0];
        else if (idx == 3)             b = t.ven[15:8];
        else if (idx == 4)             b = t.rev[7:0];
        else if (idx == 5)             b = t.rev[15:8];
        else if (idx < BID_NAME_BASE)  b = t.rsvd;
        else if (idx < BID_FILL_BASE)  b = t.name[8*(BID_FILL_BASE-1-idx) +: 8];
        else                           b = 8'hFF;
        return b;
    endfunction

endpackage

// File: rtl/bid_decode.sv
module bid_decode
    import bid_pkg::*;
#(
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned OFS_DATA = 0
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output bid_op_e           op,
    output logic              rd_ack
);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFS_DATA + 1);
    localparam logic [ADDR_W-1:0] A_RWD = ADDR_W'(OFS_DATA + 2);

    always_comb begin
        rd_ack = rd_en && !wr_en;
        op     = BID_IDLE;
        if (rd_ack) begin
            if (addr == A_LO || addr == A_HI)
                op = wide ? BID_WORD : BID_BYTE;
            else if (addr == A_RWD && !wide)
                op = BID_REWIND;
        end
    end
endmodule

// File: rtl/bid_pointer.sv
module bid_pointer
    import bid_pkg::*;
#(
    parameter int unsigned PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bid_op_e          op,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            unique case (op)
                BID_BYTE:   ptr <= ptr + PTR_W'(1);
                BID_WORD:   ptr <= ptr + PTR_W'(2);
                BID_REWIND: ptr <= '0;
                default:    ptr <= ptr;
            endcase
        end
    end
endmodule

// File: rtl/bid_rom.sv
module bid_rom
    import bid_pkg::*;
#(
    parameter int unsigned PTR_W = 8
) (
    input  bid_table_t       tbl,
    input  logic [PTR_W-1:0] idx,
    output logic [7:0]       data
);
    always_comb data = bid_lookup(tbl, 32'(idx));
endmodule

// File: rtl/board_id_reader.sv
module board_id_reader
    import bid_pkg::*;
#(
    parameter int unsigned                   PTR_W    = 8,
    parameter int unsigned                   ADDR_W   = 2,
    parameter int unsigned                   OFS_DATA = 0,
    parameter logic [15:0]                   DEV_ID   = 16'h6854,
    parameter logic [15:0]                   VEN_ID   = 16'h1435,
    parameter logic [15:0]                   REV_ID   = 16'h0102,
    parameter logic [7:0]                    RSVD     = 8'h00,
    parameter logic [8*BID_NAME_BYTES-1:0]   NAME     = {"ISODIO", 16'h0000}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic [15:0]       rdata,
    output logic              rvalid
);
    localparam int unsigned LANES = 2;
    localparam bid_table_t  TABLE = '{dev: DEV_ID, ven: VEN_ID, rev: REV_ID,
                                      rsvd: RSVD, name: NAME};

    bid_op_e          op;
    logic             rd_ack;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       lane [LANES];

    bid_decode #(.ADDR_W(ADDR_W), .OFS_DATA(OFS_DATA)) u_dec (
        .rd_en (rd_en),
        .wr_en (wr_en),
        .addr  (addr),
        .wide  (wide),
        .op    (op),
        .rd_ack(rd_ack)
    );

    bid_pointer #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk),
        .rst(rst),
        .op (op),
        .ptr(ptr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bid_rom #(.PTR_W(PTR_W)) u_rom (
            .tbl (TABLE),
            .idx (ptr + PTR_W'(g)),
            .data(lane[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_ack;
            unique case (op)
                BID_BYTE: rdata <= {8'h00, lane[0]};
                BID_WORD: rdata <= {lane[1], lane[0]};
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/bid_checker.sv
module bid_checker
    import bid_pkg::*;
#(
    parameter int unsigned PTR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             wr_en,
    input bid_op_e          op,
    input logic [PTR_W-1:0] ptr,
    input logic [15:0]      rdata,
    input logic             rvalid
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (ptr == '0 && !rvalid && rdata == 16'h0));

    assert_byte_step_R2: assert property (@(posedge clk) disable iff (rst)
        op == BID_BYTE |=> (ptr == $past(ptr) + PTR_W'(1) && rdata[15:8] == 8'h00));

    assert_word_step_R3: assert property (@(posedge clk) disable iff (rst)
        op == BID_WORD |=> ptr == $past(ptr) + PTR_W'(2));

    assert_rewind_R4: assert property (@(posedge clk) disable iff (rst)
        op == BID_REWIND |=> (ptr == '0 && rdata == 16'h0 && rvalid));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        op == BID_IDLE |=> $stable(ptr));

    assert_read_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> rvalid);

    assert_quiet_data_R9: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> rdata == 16'h0);

    assert_collision_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |=> (!rvalid && $stable(ptr)));
endmodule

bind board_id_reader bid_checker #(.PTR_W(PTR_W)) u_bid_chk (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .op    (op),
    .ptr   (ptr),
    .rdata (rdata),
    .rvalid(rvalid)
);

// File: tb/tb_board_id_reader.sv
`timescale 1ns/1ps
module tb_board_id_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wide = 1'b0;
    logic [15:0] rdata;
    logic        rvalid;

    int checks = 0;
    int fails  = 0;
    int m_ptr  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    board_id_reader dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wide(wide), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [7:0] exp_entry(input int idx);
        logic [63:0] nm = {"ISODIO", 16'h0000};
        case (idx)
            0: return 8'h54;
            1: return 8'h68;
            2: return 8'h35;
            3: return 8'h14;
            4: return 8'h02;
            5: return 8'h01;
            default: begin
                if (idx < 10) return 8'h00;
                if (idx < 18) return nm[8*(17-idx) +: 8];
                return 8'hFF;
            end
        endcase
    endfunction

    function automatic string tag_of(input int idx);
        if (idx < 10) return "R5";
        if (idx < 18) return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // One access: drive at a falling edge, sample at the next falling edge.
    task automatic access(input bit rd, input bit wr, input logic [1:0] a, input bit w,
                          input string req);
        logic [15:0] e_data;
        bit          e_valid;
        string       r;
        int          p0;
        p0      = m_ptr;
        r       = req;
        e_valid = rd && !wr;
        e_data  = 16'h0;
        if (rd && !wr) begin
            if (a <= 2'd1) begin
                if (w) begin
                    e_data = {exp_entry((p0 + 1) % 256), exp_entry(p0)};
                    m_ptr  = (p0 + 2) % 256;
                    if (r == "") r = (p0 == 255) ? "R8" : "R3";
                end else begin
                    e_data = {8'h00, exp_entry(p0)};
                    m_ptr  = (p0 + 1) % 256;
                    if (r == "") r = tag_of(p0);
                end
            end else if (a == 2'd2 && !w) begin
                m_ptr = 0;
                if (r == "") r = "R4";
            end else if (r == "") r = (a == 2'd2) ? "R4" : "R9";
        end else if (r == "") r = wr && rd ? "R10" : "R9";
        rd_en = rd; wr_en = wr; addr = a; wide = w;
        @(negedge clk);
        check(rvalid === e_valid && rdata === e_data, r, "rvalid/rdata",
              {rvalid, rdata}, {e_valid, e_data});
        rd_en = 1'b0; wr_en = 1'b0; wide = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rvalid === 1'b0 && rdata === 16'h0, "R1", "reset outputs",
              {rvalid, rdata}, 17'h0);
        access(1, 0, 2'd0, 0, "R1");          // first byte after reset is entry 0

        access(1, 0, 2'd2, 0, "R4");          // rewind
        for (int i = 0; i < 20; i++) access(1, 0, 2'(i % 2), 0, ""); // R2 R5 R6 R7
        access(1, 0, 2'd2, 0, "R4");
        for (int i = 0; i < 9; i++) access(1, 0, 2'(i % 2), 1, "R3");

        // R9: writes and offset-3 reads leave the index alone
        for (int a = 0; a < 4; a++) access(0, 1, 2'(a), 0, "R9");
        access(1, 0, 2'd3, 0, "R9");
        access(1, 0, 2'd3, 1, "R9");
        access(1, 0, 2'd1, 0, "R9");          // index visible through next read

        // R4: word read at rewind offset does not rewind
        access(1, 0, 2'd2, 1, "R4");
        access(1, 0, 2'd0, 0, "R4");

        // R10: read and write together at rewind offset, index not zero
        access(1, 1, 2'd2, 0, "R10");
        access(1, 1, 2'd0, 1, "R10");
        access(1, 0, 2'd0, 0, "R10");

        // R8: walk to 255 and fetch a word across the wrap
        access(1, 0, 2'd2, 0, "R4");
        for (int i = 0; i < 127; i++) access(1, 0, 2'd0, 1, "");
        access(1, 0, 2'd1, 0, "R7");
        access(1, 0, 2'd0, 1, "R8");
        access(1, 0, 2'd0, 0, "R8");          // entry 1 after the wrap

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom();
            access(r[0] | r[1], r[2] & r[3] & r[4], r[6:5], r[7], "");
        end

        report();
    end
endmodule